// File: doc/BRIEF.md
# Counted Serial Result Port

This block is the read-only serial output of an 8-bit converter. It holds the most recently latched conversion result and sends it out one bit per serial clock, most significant bit first. A rising edge on the port-enable input arms the port and clears its bit counter. The first rising serial clock edge after that drives the first bit and enables the output driver, and the falling edge of the eighth serial clock releases the driver again. Serial clock edges seen while the port is not armed are ignored, and so are edges after the eighth bit until the port-enable input rises again. The serial clock may run continuously or in bursts.

The converter's sequencer hands the port a new result through a one-cycle parallel load. The load is accepted at once when no transfer is running. A load that arrives during a transfer is held and applied when that transfer ends, so a read started before a conversion finishes returns the previous result. The port does not depend on the converter core being powered. Both `sclk` and `port_en` are sampled by the system clock `clk`, and each output responds in the `clk` cycle after the edge is sampled.

Top module: `ser_result_port`

## Requirements
- R1: After reset, `sdo_oe` is 0 and `sdo` is 0. `sdo` is always 0 whenever `sdo_oe` is 0.
- R2: Until the first rising edge of `port_en` after reset, rising and falling edges of `sclk` leave `sdo_oe` at 0.
- R3: After a `port_en` rise, the first `sclk` rising edge sets `sdo_oe` to 1 and drives bit 7 of the held result on `sdo`. Each later rising edge drives the next lower bit, so bit 0 is the eighth bit.
- R4: Once eight bits have been sent, further `sclk` edges keep `sdo_oe` at 0 and `sdo` at 0 until `port_en` rises again. A new `port_en` rise then starts a complete new transfer.
- R5: `sdo_oe` falls on the falling `sclk` edge that follows the eighth rising edge, and not on any earlier falling edge of the transfer.
- R6: A load pulse (`load_valid`=1 for one `clk` cycle) that arrives while `sdo_oe` is 0 replaces the held result. Transfers that start afterwards send the new value, and transfers that start before the load send the previous value.
- R7: A load that arrives while `sdo_oe` is 1 does not change the bits of the running transfer. It becomes the held result when the transfer ends. If several loads arrive during one transfer, the last one wins.
- R8: A `port_en` rise during a transfer sets `sdo_oe` to 0 and clears the bit counter. The next `sclk` rising edge restarts the transfer at bit 7.
- R9: Only the rising edge of `port_en` has an effect. Lowering `port_en` during or between transfers does not change `sdo`, `sdo_oe` or the bit count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample all inputs |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk | input | 1 | Serial clock from the host |
| port_en | input | 1 | Port enable; its rising edge arms the port and clears the bit count |
| load_valid | input | 1 | One-cycle strobe for a new conversion result |
| load_data | input | 8 | New conversion result |
| sdo | output | 1 | Serial data, most significant bit first |
| sdo_oe | output | 1 | Output-driver enable; 0 means high impedance |

## Verification
The hardest case to reach is a load that arrives while a transfer is running. It must stay out of the bits of that transfer and appear only in the next one, possibly after a restart caused by a `port_en` rise in the middle of the transfer. The random stimulus mixes loads, serial clock pulses, `port_en` pulses and drops in arbitrary order, so loads often fall inside a transfer and restarts often cut one short. A reference model in the bench tracks the held result, the pending load and the bit count, and predicts every output. Directed sequences add a double load during one transfer, a restart after four bits, and clock pulses beyond the eighth bit.

// File: rtl/ser_result_port.sv
module ser_result_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sclk,
  input  logic         port_en,
  input  logic         load_valid,
  input  logic [W-1:0] load_data,
  output logic         sdo,
  output logic         sdo_oe
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] LAST = CW'(W);

  logic         sclk_q, en_q, armed, oe, pv;
  logic [CW-1:0] cnt;
  logic [W-1:0] res, pend, shreg;

  wire en_rise = port_en & ~en_q;
  wire s_rise  = sclk & ~sclk_q;
  wire s_fall  = ~sclk & sclk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      en_q   <= 1'b0;
      armed  <= 1'b0;
      oe     <= 1'b0;
      pv     <= 1'b0;
      cnt    <= '0;
      res    <= '0;
      pend   <= '0;
      shreg  <= '0;
    end else begin
      sclk_q <= sclk;
      en_q   <= port_en;
      if (en_rise) begin
        cnt   <= '0;
        armed <= 1'b1;
        oe    <= 1'b0;
      end else if (s_rise && armed && cnt != LAST) begin
        if (cnt == '0) begin
          shreg <= res;
          oe    <= 1'b1;
        end else begin
          shreg <= {shreg[W-2:0], 1'b0};
        end
        cnt <= cnt + 1'b1;
      end else if (s_fall && oe && cnt == LAST) begin
        oe    <= 1'b0;
        armed <= 1'b0;
      end
      if (!oe) begin
        if (load_valid) begin
          res <= load_data;
          pv  <= 1'b0;
        end else if (pv) begin
          res <= pend;
          pv  <= 1'b0;
        end
      end else if (load_valid) begin
        pend <= load_data;
        pv   <= 1'b1;
      end
    end
  end

  assign sdo_oe = oe;
  assign sdo    = oe & shreg[W-1];

  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
  a_r2_oe_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe) |-> $past(armed) && $past(s_rise));
  a_r5_oe_drop_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe) |-> $past(en_rise) || ($past(s_fall) && $past(cnt) == LAST));
  a_r7_res_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    oe && $past(oe) |-> $stable(res));
  a_r3_sdo_steady: assert property (@(posedge clk) disable iff (!rst_n)
    oe && $past(oe) && !$past(s_rise) |-> $stable(sdo));
  a_r1_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !sdo_oe |-> !sdo);
endmodule

// File: tb/test_ser_result_port.sv
module test_ser_result_port;
  logic clk = 0, rst_n = 0, sclk = 0, port_en = 0, load_valid = 0;
  logic [7:0] load_data = 0;
  logic sdo, sdo_oe;
  int errors = 0, checks = 0;

  logic [7:0] m_res = 0, m_pend = 0, m_sh = 0;
  bit m_pv = 0, m_armed = 0, m_oe = 0;
  int m_cnt = 0;

  always #2 clk = ~clk;

  ser_result_port #(.W(8)) i_ser_result_port (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .port_en(port_en),
    .load_valid(load_valid), .load_data(load_data), .sdo(sdo), .sdo_oe(sdo_oe));

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  function automatic bit exp_sdo();
    return m_oe & m_sh[7];
  endfunction

  task automatic check(string req);
    checks++;
    if (sdo_oe !== m_oe || sdo !== exp_sdo()) begin
      errors++;
      $display("FAIL %s: oe=%0b sdo=%0b expected oe=%0b sdo=%0b", req, sdo_oe, sdo, m_oe, exp_sdo());
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic end_xfer();
    m_oe = 0;
    if (m_pv) begin m_res = m_pend; m_pv = 0; end
  endtask

  task automatic en_pulse(string req);
    port_en = 0; tick();
    port_en = 1; tick(); tick();
    m_cnt = 0; m_armed = 1;
    if (m_oe) end_xfer();
    check(req);
  endtask

  task automatic en_low(string req);
    port_en = 0; tick(); tick();
    check(req);
  endtask

  task automatic sclk_pulse(string req);
    sclk = 1; tick(); tick();
    if (m_armed && m_cnt < 8) begin
      if (m_cnt == 0) begin m_sh = m_res; m_oe = 1; end
      else m_sh = m_sh << 1;
      m_cnt++;
    end
    check(req);
    sclk = 0; tick(); tick();
    if (m_oe && m_cnt == 8) begin end_xfer(); m_armed = 0; end
    check(req);
  endtask

  task automatic load(logic [7:0] d);
    load_data = d; load_valid = 1; tick();
    load_valid = 0; tick(); tick();
    if (!m_oe) begin m_res = d; m_pv = 0; end
    else begin m_pend = d; m_pv = 1; end
  endtask

  initial begin
    void'($urandom(32'h5eed));
    tick(); tick();
    check("R1 reset");
    rst_n = 1; tick();
    check("R1 after reset");
    for (int i = 0; i < 3; i++) sclk_pulse("R2 no arm");
    load(8'hA5);
    en_pulse("R3 arm");
    for (int i = 0; i < 8; i++) sclk_pulse("R3 R5 bit order");
    for (int i = 0; i < 3; i++) sclk_pulse("R4 extra edges");
    en_pulse("R4 rearm");
    for (int i = 0; i < 8; i++) sclk_pulse("R4 second transfer");
    en_pulse("R6 arm");
    sclk_pulse("R7 first bit");
    load(8'h3C);
    load(8'hC3);
    for (int i = 0; i < 7; i++) sclk_pulse("R7 held load");
    en_pulse("R7 arm");
    for (int i = 0; i < 8; i++) sclk_pulse("R7 last load wins");
    load(8'h96);
    en_pulse("R8 arm");
    for (int i = 0; i < 4; i++) sclk_pulse("R8 partial");
    en_pulse("R8 restart");
    en_low("R9 drop");
    for (int i = 0; i < 8; i++) sclk_pulse("R8 R9 restart from bit 7");
    for (int i = 0; i < 400; i++) begin
      int a = int'($urandom_range(0, 9));
      if (a == 0) en_pulse("R8 random arm");
      else if (a == 1) en_low("R9 random drop");
      else if (a == 2) load(8'($urandom));
      else sclk_pulse("R3 random shift");
    end
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule